// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupt Triggers

This block is a bank of 32 general-purpose I/O lines sitting behind a small 32-bit register bus. Each line has an output bit and a direction bit. Software changes either one through dedicated set and clear addresses, so it never has to do a read-modify-write. The pad inputs pass through a two-flop synchroniser, and software can read the result. The bank drives the pad output and output-enable vectors directly.

The lowest eight lines can raise interrupts. One 32-bit control word holds four byte fields, one bit per interrupt line in each:

| Bits | Field |
|------|-------|
| [7:0] | rise enable |
| [15:8] | fall enable |
| [23:16] | debounce enable |
| [31:24] | level mode |

Software changes this word only through bitwise set and clear addresses.

Each interrupt line decodes its three trigger bits (level, rise, fall) into one of seven trigger states:

| State | {level, rise, fall} |
|-------|---------------------|
| TRIG_OFF | 000 or 100 |
| TRIG_FALL | 001 |
| TRIG_RISE | 010 |
| TRIG_BOTH | 011 |
| TRIG_LOW | 101 |
| TRIG_HIGH | 110 |
| TRIG_ANY | 111 |

Edge states drive a two-state pending flag, IDLE or PENDING:

- The move IDLE to PENDING happens on an enabled edge.
- The move PENDING to IDLE happens on a write-one acknowledge, or when the line enters level mode.

Level states bypass the flag, so the status bit follows the enabled level live. One interrupt output is the OR of all status bits.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the following are all zero:
  - the output, direction and interrupt-control registers;
  - the interrupt status;
  - the pad_out, pad_oe and irq outputs.
- R2: Output bits follow the writes below; pad_out shows the register, and reads at 0x10 and 0x14 return it.
  - Writing 0x10 sets the output bits at the positions of the written ones.
  - Writing 0x14 clears the output bits at the positions of the written ones.
  - Bits written as zero are unchanged.
- R3: Direction bits follow the writes below (1 means drive). pad_oe equals the direction register, and reads at 0x00 return it.
  - Writing ones to 0x04 makes the selected lines outputs.
  - Writing ones to 0x08 makes the selected lines inputs.
  - Other lines are unchanged.
- R4: A read at 0x0C returns the pad inputs through two flops. A pad change driven after clock edge N is first visible in the read after edge N+2.
- R5: The interrupt control word is changed in two ways, and reads at 0x18 or 0x1C return it:
  - writing 0x18 ORs in the written bits;
  - writing 0x1C clears the written bits.
  - The field layout is rise [7:0], fall [15:8], debounce [23:16], level [31:24], with bit n of each field belonging to line n.
- R6: With its level bit clear, a line behaves as follows:
  - with rise set, it latches pending status on a synchronised 0-to-1 edge;
  - with fall set, it latches pending status on a 1-to-0 edge;
  - with both set, it latches on either edge.
  - A pad change after edge N shows in status after edge N+3.
- R7: With its level bit set, a line's status behaves as follows:
  - with rise set, status equals the synchronised pad value (active high);
  - with fall set, status equals its inverse (active low);
  - status is not latched, so an acknowledge has no lasting effect;
  - any edge-pending status is discarded while the line is in level mode.
- R8: Writing ones to 0x20 clears the pending edge status of the selected lines. An edge detected in the same cycle wins over the acknowledge.
- R9: A line with rise and fall both clear sets no new status, but pending status it already holds stays until acknowledged.
- R10: Only lines 0 to 7 raise interrupts. Status bits 8 to 31 always read as zero, whatever lines 8 to 31 do.
- R11: A read at 0x24 returns the status. The irq output is high exactly when any status bit is set.
- R12: Debounce bits are stored and read back but do not change detection or its latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; register write on this clock edge |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables, 1 drives |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situations to reach from the ports are those where a line's trigger state changes while it still holds edge status:

- a pending flag that must survive masking;
- a pending flag that must vanish when the line enters level mode and stay gone when it returns to edge mode;
- a level status that an acknowledge cannot remove.

The stimulus builds each of these by first latching an edge with the pad held still. It then rewrites the control word through its set and clear addresses. It reads the status before and after each control write, and again after an acknowledge. Latency is pinned down by reading the pin and status registers on consecutive cycles after a single pad change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] REG_DIR     = 6'h00;
    localparam logic [ADDR_W-1:0] REG_DIR_OUT = 6'h04;
    localparam logic [ADDR_W-1:0] REG_DIR_IN  = 6'h08;
    localparam logic [ADDR_W-1:0] REG_PIN     = 6'h0C;
    localparam logic [ADDR_W-1:0] REG_OSET    = 6'h10;
    localparam logic [ADDR_W-1:0] REG_OCLR    = 6'h14;
    localparam logic [ADDR_W-1:0] REG_CSET    = 6'h18;
    localparam logic [ADDR_W-1:0] REG_CCLR    = 6'h1C;
    localparam logic [ADDR_W-1:0] REG_ACK     = 6'h20;
    localparam logic [ADDR_W-1:0] REG_STAT    = 6'h24;

    typedef enum logic [2:0] {
        TRIG_OFF,
        TRIG_RISE,
        TRIG_FALL,
        TRIG_BOTH,
        TRIG_HIGH,
        TRIG_LOW,
        TRIG_ANY
    } trig_mode_e;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] sync_prev
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
            prev_q   <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
            prev_q   <= stable_q;
        end
    end

    assign sync_out  = stable_q;
    assign sync_prev = prev_q;

endmodule

// File: rtl/gpio_bank_trig.sv
module gpio_bank_trig
    import gpio_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_cur,
    input  logic line_prev,
    input  logic rise_en,
    input  logic fall_en,
    input  logic level_en,
    input  logic ack,
    output logic status
);

    trig_mode_e mode;
    logic       edge_hit;
    logic       level_hit;
    logic       pend_q;

    // Trigger state decode from {level, rise, fall}.
    always_comb begin
        unique case ({level_en, rise_en, fall_en})
            3'b000:  mode = TRIG_OFF;
            3'b001:  mode = TRIG_FALL;
            3'b010:  mode = TRIG_RISE;
            3'b011:  mode = TRIG_BOTH;
            3'b100:  mode = TRIG_OFF;
            3'b101:  mode = TRIG_LOW;
            3'b110:  mode = TRIG_HIGH;
            default: mode = TRIG_ANY;
        endcase
    end

    always_comb begin
        edge_hit  = 1'b0;
        level_hit = 1'b0;
        unique case (mode)
            TRIG_OFF:  ;
            TRIG_RISE: edge_hit  = line_cur & ~line_prev;
            TRIG_FALL: edge_hit  = ~line_cur & line_prev;
            TRIG_BOTH: edge_hit  = line_cur ^ line_prev;
            TRIG_HIGH: level_hit = line_cur;
            TRIG_LOW:  level_hit = ~line_cur;
            TRIG_ANY:  level_hit = 1'b1;
            default:   ;
        endcase
    end

    // Pending flag: IDLE -> PENDING on edge, back on ack or level entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (level_en) begin
            pend_q <= 1'b0;
        end else if (edge_hit) begin
            pend_q <= 1'b1;
        end else if (ack) begin
            pend_q <= 1'b0;
        end
    end

    assign status = level_en ? level_hit : pend_q;

    assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_en && rise_en && line_cur && !line_prev) |=> pend_q);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !level_en && (line_cur == line_prev)) |=> !pend_q);

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_en && !fall_en && !pend_q) |=> !pend_q);

    assert_level_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (level_en && rise_en && !fall_en) |-> (status == line_cur));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_IRQ   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic                 irq
);

    localparam int CTRL_W  = 4 * NUM_IRQ;
    localparam int RISE_LO = 0;
    localparam int FALL_LO = NUM_IRQ;
    localparam int LVL_LO  = 3 * NUM_IRQ;

    logic [NUM_LINES-1:0] out_q;
    logic [NUM_LINES-1:0] dir_q;
    logic [CTRL_W-1:0]    ctrl_q;
    logic [NUM_LINES-1:0] pin_sync;
    logic [NUM_LINES-1:0] pin_prev;
    logic [NUM_IRQ-1:0]   ack_vec;
    logic [NUM_IRQ-1:0]   irq_status;

    gpio_bank_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (pad_in),
        .sync_out  (pin_sync),
        .sync_prev (pin_prev)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            ctrl_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                REG_DIR_OUT: dir_q  <= dir_q | bus_wdata;
                REG_DIR_IN:  dir_q  <= dir_q & ~bus_wdata;
                REG_OSET:    out_q  <= out_q | bus_wdata;
                REG_OCLR:    out_q  <= out_q & ~bus_wdata;
                REG_CSET:    ctrl_q <= ctrl_q | bus_wdata[CTRL_W-1:0];
                REG_CCLR:    ctrl_q <= ctrl_q & ~bus_wdata[CTRL_W-1:0];
                default:     ;
            endcase
        end
    end

    assign ack_vec = (bus_wr && bus_addr == REG_ACK) ? bus_wdata[NUM_IRQ-1:0] : '0;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_trig
        gpio_bank_trig u_trig (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_cur  (pin_sync[i]),
            .line_prev (pin_prev[i]),
            .rise_en   (ctrl_q[RISE_LO + i]),
            .fall_en   (ctrl_q[FALL_LO + i]),
            .level_en  (ctrl_q[LVL_LO + i]),
            .ack       (ack_vec[i]),
            .status    (irq_status[i])
        );
    end

    always_comb begin
        case (bus_addr)
            REG_DIR, REG_DIR_OUT, REG_DIR_IN: bus_rdata = dir_q;
            REG_PIN:                          bus_rdata = pin_sync;
            REG_OSET, REG_OCLR:               bus_rdata = out_q;
            REG_CSET, REG_CCLR:               bus_rdata = NUM_LINES'(ctrl_q);
            REG_STAT:                         bus_rdata = NUM_LINES'(irq_status);
            default:                          bus_rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
    assign irq     = |irq_status;

    assert_out_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_OSET) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

    assert_out_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_OCLR) |=>
        ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));

    assert_dir_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIR_IN) |=> ((pad_oe & $past(bus_wdata)) == '0));

    assert_no_ack_write_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ACK) |=> $stable(pad_out) && $stable(pad_oe));

endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    gpio_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    // Monitor: pops expected items and compares away from the active edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'b0, irq};
                2:       act = pad_out;
                default: act = pad_oe;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk);
        #1;
        bus_addr = a;
        push(0, exp, tag);
    endtask

    task automatic chk(input int kind, input logic [31:0] exp, input string tag);
        push(kind, exp, tag);
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(posedge clk);
        #1;
        pad_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(6'h00, 32'h0, "R1 direction");
        rd(6'h10, 32'h0, "R1 output");
        rd(6'h18, 32'h0, "R1 control");
        rd(6'h24, 32'h0, "R1 status");
        chk(1, 32'h0, "R1 irq");
        chk(2, 32'h0, "R1 pad_out");
        chk(3, 32'h0, "R1 pad_oe");

        // R2 output set / clear
        wr(6'h10, 32'hA5A5_0F0F);
        rd(6'h10, 32'hA5A5_0F0F, "R2 set");
        wr(6'h14, 32'h0000_000F);
        rd(6'h14, 32'hA5A5_0F00, "R2 clear");
        wr(6'h10, 32'h0);
        chk(2, 32'hA5A5_0F00, "R2 zero write keeps");

        // R3 direction
        wr(6'h04, 32'hFF00_00FF);
        wr(6'h08, 32'h0F00_0001);
        rd(6'h00, 32'hF000_00FE, "R3 direction read");
        chk(3, 32'hF000_00FE, "R3 pad_oe");

        // R4 pin sync latency
        set_pad(32'h1234_5678);
        rd(6'h0C, 32'h0, "R4 one edge");
        rd(6'h0C, 32'h1234_5678, "R4 two edges");
        set_pad(32'h0);
        idle(4);

        // R5 control word
        wr(6'h18, 32'hF0F0_00FF);
        wr(6'h1C, 32'h3030_00F0);
        rd(6'h18, 32'hC0C0_000F, "R5 read set addr");
        rd(6'h1C, 32'hC0C0_000F, "R5 read clear addr");
        wr(6'h1C, 32'hFFFF_FFFF);
        rd(6'h18, 32'h0, "R5 cleared");

        // R6 rising edge, line 0, latency
        wr(6'h18, 32'h0000_0001);
        set_pad(32'h1);
        rd(6'h24, 32'h0, "R6 edge+1");
        rd(6'h24, 32'h0, "R6 edge+2");
        rd(6'h24, 32'h1, "R6 edge+3");
        chk(1, 32'h1, "R11 irq high");
        wr(6'h20, 32'h1);
        rd(6'h24, 32'h0, "R8 ack clears");
        chk(1, 32'h0, "R11 irq low");
        set_pad(32'h0);
        idle(4);
        rd(6'h24, 32'h0, "R6 rise ignores fall");

        // R6 falling edge, line 1
        wr(6'h18, 32'h0000_0200);
        set_pad(32'h2);
        idle(4);
        rd(6'h24, 32'h0, "R6 fall ignores rise");
        set_pad(32'h0);
        idle(4);
        rd(6'h24, 32'h2, "R6 fall detected");
        wr(6'h20, 32'h2);

        // R6 both edges, line 4
        wr(6'h18, 32'h0000_1010);
        set_pad(32'h10);
        idle(4);
        rd(6'h24, 32'h10, "R6 both rise");
        wr(6'h20, 32'h10);
        set_pad(32'h0);
        idle(4);
        rd(6'h24, 32'h10, "R6 both fall");
        wr(6'h20, 32'h10);
        rd(6'h24, 32'h0, "R8 ack both");

        // R9 mask keeps pending, blocks new
        set_pad(32'h10);
        idle(4);
        wr(6'h1C, 32'h0000_1010);
        rd(6'h24, 32'h10, "R9 pending retained");
        wr(6'h20, 32'h10);
        set_pad(32'h0);
        idle(4);
        rd(6'h24, 32'h0, "R9 masked no new");
        chk(1, 32'h0, "R9 irq low");

        // R12 debounce stored, no effect
        wr(6'h18, 32'h0001_0000);
        rd(6'h18, 32'h0001_0201, "R12 readback");
        set_pad(32'h1);
        idle(2);
        rd(6'h24, 32'h1, "R12 same latency");
        wr(6'h20, 32'h1);
        set_pad(32'h0);
        idle(4);

        // R7 level high, line 2
        wr(6'h18, 32'h0400_0004);
        rd(6'h24, 32'h0, "R7 high idle");
        set_pad(32'h4);
        rd(6'h24, 32'h0, "R7 high edge+1");
        rd(6'h24, 32'h4, "R7 high edge+2");
        wr(6'h20, 32'h4);
        rd(6'h24, 32'h4, "R7 ack no lasting effect");
        set_pad(32'h0);
        idle(4);
        rd(6'h24, 32'h0, "R7 high released");
        chk(1, 32'h0, "R7 irq low");

        // R7 level low, line 3
        wr(6'h18, 32'h0800_0800);
        rd(6'h24, 32'h8, "R7 low active");
        chk(1, 32'h1, "R11 irq level");
        set_pad(32'h8);
        idle(4);
        rd(6'h24, 32'h0, "R7 low released");
        wr(6'h1C, 32'h0C00_0C04);

        // R7 level entry discards edge pending, line 5
        wr(6'h18, 32'h0000_0020);
        set_pad(32'h28);
        idle(4);
        set_pad(32'h08);
        idle(4);
        rd(6'h24, 32'h20, "R7 edge pending before");
        wr(6'h18, 32'h2000_0000);
        rd(6'h24, 32'h0, "R7 level pad low");
        wr(6'h1C, 32'h2000_0000);
        rd(6'h24, 32'h0, "R7 pending discarded");
        wr(6'h1C, 32'h0000_0020);

        // R10 upper lines never interrupt
        set_pad(32'hFFFF_FF08);
        idle(4);
        rd(6'h24, 32'h0, "R10 upper lines quiet");
        wr(6'h18, 32'h0000_00FF);
        set_pad(32'hFFFF_FFFF);
        idle(4);
        rd(6'h24, 32'h0000_00F7, "R10 only low byte");
        chk(1, 32'h1, "R11 irq any");
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h24, 32'h0, "R8 ack all");
        chk(1, 32'h0, "R11 irq cleared");

        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule